// File: doc/BRIEF.md
# Fault Shutdown Latch Controller

This block is the digital control path for fast fault shutdown in a half-bridge gate driver. It receives a current-sense comparator trip that is not synchronised to the clock. It also receives the level of a shared active-low shutdown line, which other logic has already turned into two threshold flags. The block drives an open-drain pull-down enable for that line and a gate-kill signal. It also drives the gated high-side and low-side outputs.

When the comparator trips, the block kills the gates at the next clock edge, without waiting for the line to fall. It also turns on the pull-down, and keeps it on until the line is sensed below its lower threshold. After release, an external RC recharges the line, and that RC alone sets how long the gates stay off. A low level driven onto the line from outside is not latched. Once the line recovers, the gates follow their requests again, so the line can be used for PWM chopping.

Top module: `fault_shutdown_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), pulldown_en is 0, gate_kill is 1 and both gate outputs are 0. The kill stays on until line_above_hi has been sampled high.
- R2: A comparator trip rise is captured by one flop. gate_kill is 1 after the first rising edge that samples trip_in high, while the line may still be above its lower threshold.
- R3: A rising trip (after the two-flop synchroniser) sets pulldown_en at the second rising edge after trip_in goes high. pulldown_en then stays 1 for as long as line_below_lo is sampled 0.
- R4: pulldown_en returns to 0 at the first rising edge that samples line_below_lo high while it is set.
- R5: After the pull-down is released, gate_kill stays 1 until a rising edge samples line_above_hi high.
- R6: The line state has hysteresis. It becomes "high" only on line_above_hi and "low" only on line_below_lo. A dip that stays between the two thresholds does not change gate_kill.
- R7: An external low on the line asserts gate_kill once line_below_lo is sampled, and never sets pulldown_en. When line_above_hi is sampled again, gate_kill clears and the outputs follow gate_req.
- R8: A new trip rise while the pull-down is on keeps it on. A trip held high after release does not set the pull-down again; only a fresh rise does.
- R9: Bit 1 of gate_req/gate_out is the high side and bit 0 is the low side. While gate_kill is 1, gate_out is 0. Otherwise gate_out equals gate_req.
- R10: A synchronous reset during an active pull-down clears pulldown_en and sets gate_kill at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trip_in | input | 1 | Comparator trip flag, asynchronous |
| line_above_hi | input | 1 | Shutdown line sensed above the upper threshold |
| line_below_lo | input | 1 | Shutdown line sensed below the lower threshold |
| gate_req | input | NUM_GATES | Gate requests from the control logic (1 = high side, 0 = low side) |
| pulldown_en | output | 1 | Enable for the open-drain pull-down on the shutdown line |
| gate_kill | output | 1 | Forces all gate outputs off |
| gate_out | output | NUM_GATES | Gate requests after masking by the kill |

## Verification
A line state stuck at the wrong value shows up at the ports within one edge of the flag that should have moved it. gate_kill either stays on past a sampled upper-threshold flag, or drops during a dip that stayed between the thresholds. A wrong pull-down state shows up as pulldown_en still set on the edge after the lower flag is seen, or set during an external drive. It also shows up as pulldown_en re-armed by a trip that was held high. A broken fast path shows up as gate_out still following gate_req in the cycle after trip_in is first sampled.

// File: rtl/fsd_pkg.sv
// Shared types and constants for the fault shutdown latch controller.
// Assumes: a half-bridge with one high-side and one low-side gate.
package fsd_pkg;
    // Pull-down control state.
    typedef enum logic [0:0] {
        PD_IDLE = 1'b0,
        PD_HOLD = 1'b1
    } pd_state_e;

    // Bit positions of the two gates in gate_req / gate_out.
    localparam int GATE_LO_IDX = 0;
    localparam int GATE_HI_IDX = 1;
endpackage

// File: rtl/fsd_trip_sync.sv
// Two-flop synchroniser for the comparator trip, with rising-edge detection.
// The edge is taken from the first flop against the second one, so a trip is
// seen one edge after it is sampled. Assumes a trip pulse lasts at least one
// clock period.
module fsd_trip_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_raw,
    output logic trip_rise
);
    logic stage1_q;
    logic stage2_q;

    // Capture the asynchronous trip, then retime it once more.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= 1'b0;
            stage2_q <= 1'b0;
        end else begin
            stage1_q <= trip_raw;
            stage2_q <= stage1_q;
        end
    end

    // A new trip is a first-stage high that the second stage has not seen yet.
    assign trip_rise = stage1_q & ~stage2_q;
endmodule

// File: rtl/fsd_line_decode.sv
// Hysteretic decode of the shared shutdown line from its two threshold flags.
// It is "high" once the upper flag is seen, and "low" once the lower flag is
// seen. Between the thresholds it holds. Reset reads the line as low.
// Assumes the flags are already synchronous and never both set.
module fsd_line_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic above_hi,
    input  logic below_lo,
    output logic line_high
);
    logic line_high_q;

    // Track the line level with hysteresis.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_high_q <= 1'b0;
        end else if (above_hi) begin
            line_high_q <= 1'b1;
        end else if (below_lo) begin
            line_high_q <= 1'b0;
        end
    end

    assign line_high = line_high_q;
endmodule

// File: rtl/fsd_pulldown_fsm.sv
// Open-drain pull-down control. A trip rise arms the pull-down, and the lower
// threshold flag releases it. A trip rise while armed changes nothing.
// Assumes trip_rise is a single-cycle pulse per trip.
module fsd_pulldown_fsm
    import fsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trip_rise,
    input  logic below_lo,
    output logic pd_active
);
    pd_state_e state_q;
    pd_state_e state_d;

    // Next-state choice between idle and holding the line down.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_IDLE: if (trip_rise) state_d = PD_HOLD;
            PD_HOLD: if (below_lo)  state_d = PD_IDLE;
            default:                state_d = PD_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign pd_active = (state_q == PD_HOLD);
endmodule

// File: rtl/fsd_gate_mask.sv
// Masks every gate request with the kill signal. When killed, all gates are
// low and the half-bridge is left tri-stated. Purely combinational.
module fsd_gate_mask #(
    parameter int NUM_GATES = 2
) (
    input  logic [NUM_GATES-1:0] req,
    input  logic                 kill,
    output logic [NUM_GATES-1:0] gate
);
    // One AND gate per output.
    for (genvar g = 0; g < NUM_GATES; g++) begin : g_mask
        assign gate[g] = req[g] & ~kill;
    end
endmodule

// File: rtl/fault_shutdown_ctrl.sv
// Top of the fault shutdown latch controller. The fast path kills the gates
// from the first synchroniser flop. The latched pull-down holds the shared line
// until it falls below the lower threshold. The hysteretic line state keeps the
// gates off until the external RC recharges the line.
// Assumes the line flags come from synchronised comparators on the pad.
module fault_shutdown_ctrl #(
    parameter int NUM_GATES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trip_in,
    input  logic                 line_above_hi,
    input  logic                 line_below_lo,
    input  logic [NUM_GATES-1:0] gate_req,
    output logic                 pulldown_en,
    output logic                 gate_kill,
    output logic [NUM_GATES-1:0] gate_out
);
    logic trip_rise;
    logic line_high;
    logic pd_active;

    fsd_trip_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .trip_raw  (trip_in),
        .trip_rise (trip_rise)
    );

    fsd_line_decode u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .above_hi  (line_above_hi),
        .below_lo  (line_below_lo),
        .line_high (line_high)
    );

    fsd_pulldown_fsm u_pd (
        .clk       (clk),
        .rst_n     (rst_n),
        .trip_rise (trip_rise),
        .below_lo  (line_below_lo),
        .pd_active (pd_active)
    );

    // The kill is on for a fresh trip, while the pull-down is on, or while the line is low.
    assign gate_kill   = trip_rise | pd_active | ~line_high;
    assign pulldown_en = pd_active;

    fsd_gate_mask #(.NUM_GATES(NUM_GATES)) u_mask (
        .req  (gate_req),
        .kill (gate_kill),
        .gate (gate_out)
    );
endmodule

// File: rtl/fault_shutdown_ctrl_chk.sv
// Port-level temporal checks for fault_shutdown_ctrl, attached with bind.
module fault_shutdown_ctrl_chk #(
    parameter int NUM_GATES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 trip_in,
    input logic                 line_above_hi,
    input logic                 line_below_lo,
    input logic [NUM_GATES-1:0] gate_req,
    input logic                 pulldown_en,
    input logic                 gate_kill,
    input logic [NUM_GATES-1:0] gate_out
);
    // R2
    trip_fast_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_in && !$past(trip_in)) |=> gate_kill);

    // R3
    pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulldown_en && !line_below_lo) |=> pulldown_en);

    // R4
    pd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulldown_en && line_below_lo) |=> !pulldown_en);

    // R5
    kill_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulldown_en) |-> gate_kill);

    // R9
    gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_kill |-> (gate_out == '0));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!pulldown_en && gate_kill));
endmodule

bind fault_shutdown_ctrl fault_shutdown_ctrl_chk #(.NUM_GATES(NUM_GATES)) u_chk (.*);

// File: tb/tb_fault_shutdown_ctrl.sv
// Self-checking bench. The shutdown line is modelled as a level that falls by
// DIS_STEP per cycle while pulled down (by the block or externally), and rises
// by 1 per cycle otherwise.
module tb_fault_shutdown_ctrl;
    localparam int LVL_MAX  = 20;
    localparam int UP_TH    = 14;
    localparam int LO_TH    = 5;
    localparam int DIS_STEP = 2;
    localparam int WDOG_NS  = 2_000_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trip_in = 1'b0;
    logic       ext_low = 1'b0;
    logic       line_above_hi;
    logic       line_below_lo;
    logic [1:0] gate_req = 2'b11;
    logic       pulldown_en;
    logic       gate_kill;
    logic [1:0] gate_out;
    logic       seen_above = 1'b0;
    logic       seen_below = 1'b0;
    int         level = 0;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    fault_shutdown_ctrl #(.NUM_GATES(2)) dut (
        .clk(clk), .rst_n(rst_n), .trip_in(trip_in),
        .line_above_hi(line_above_hi), .line_below_lo(line_below_lo),
        .gate_req(gate_req), .pulldown_en(pulldown_en),
        .gate_kill(gate_kill), .gate_out(gate_out)
    );

    assign line_above_hi = (level >= UP_TH);
    assign line_below_lo = (level <= LO_TH);

    // Line model: changes away from the sampling edge.
    always @(negedge clk) begin
        if (pulldown_en || ext_low) level <= (level > DIS_STEP) ? level - DIS_STEP : 0;
        else                        level <= (level < LVL_MAX) ? level + 1 : LVL_MAX;
    end

    // The flags as the design saw them at the last rising edge.
    always @(posedge clk) begin
        seen_above <= line_above_hi;
        seen_below <= line_below_lo;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_gates(input string req);
        for (int r = 0; r < 4; r++) begin
            gate_req = r[1:0];
            #1;
            chk(gate_out == (gate_kill ? 2'b00 : r[1:0]), req, gate_out,
                gate_kill ? 0 : r);
        end
        gate_req = 2'b11;
    endtask

    task automatic wait_high(input string req);
        while (!seen_above) begin
            chk(gate_kill == 1'b1, req, gate_kill, 1);
            @(negedge clk);
        end
        chk(gate_kill == 1'b0, req, gate_kill, 0);
    endtask

    initial begin
        #(WDOG_NS);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(pulldown_en == 1'b0, "R1", pulldown_en, 0);
        chk(gate_kill == 1'b1, "R1", gate_kill, 1);
        check_gates("R1");
        rst_n = 1'b1;
        @(negedge clk);
        wait_high("R1");
        repeat (LVL_MAX) @(negedge clk);
        check_gates("R9");

        // R2: fast kill from the first flop, line still high
        trip_in = 1'b1;
        @(negedge clk);
        chk(gate_kill == 1'b1, "R2", gate_kill, 1);
        chk(seen_below == 1'b0, "R2", seen_below, 0);
        chk(pulldown_en == 1'b0, "R2", pulldown_en, 0);
        check_gates("R2");
        // R3: pull-down armed on the next edge
        @(negedge clk);
        chk(pulldown_en == 1'b1, "R3", pulldown_en, 1);
        // R3, R8: held through the discharge, retriggered once
        for (int i = 0; !seen_below; i++) begin
            if (i == 1) trip_in = 1'b0;
            if (i == 3) trip_in = 1'b1;
            chk(pulldown_en == 1'b1, "R3", pulldown_en, 1);
            chk(gate_kill == 1'b1, "R8", gate_kill, 1);
            @(negedge clk);
        end
        // R4: released on the edge that saw the lower flag
        chk(pulldown_en == 1'b0, "R4", pulldown_en, 0);
        chk(gate_kill == 1'b1, "R5", gate_kill, 1);
        // R5, R8: kill through the recharge; a trip held high does not re-arm
        while (!seen_above) begin
            chk(pulldown_en == 1'b0, "R8", pulldown_en, 0);
            chk(gate_kill == 1'b1, "R5", gate_kill, 1);
            @(negedge clk);
        end
        chk(gate_kill == 1'b0, "R5", gate_kill, 0);
        check_gates("R9");
        trip_in = 1'b0;
        repeat (LVL_MAX) @(negedge clk);

        // R6: dip into the band between thresholds does not kill
        ext_low = 1'b1;
        while (level > 9) @(negedge clk);
        ext_low = 1'b0;
        for (int i = 0; i < LVL_MAX; i++) begin
            chk(gate_kill == 1'b0, "R6", gate_kill, 0);
            chk(seen_below == 1'b0, "R6", seen_below, 0);
            @(negedge clk);
        end

        // R7: external PWM chopping, two pulses, not latched
        for (int p = 0; p < 2; p++) begin
            ext_low = 1'b1;
            while (!seen_below) begin
                chk(gate_kill == 1'b0, "R6", gate_kill, 0);
                chk(pulldown_en == 1'b0, "R7", pulldown_en, 0);
                @(negedge clk);
            end
            chk(gate_kill == 1'b1, "R7", gate_kill, 1);
            check_gates("R7");
            ext_low = 1'b0;
            while (!seen_above) begin
                chk(gate_kill == 1'b1, "R6", gate_kill, 1);
                chk(pulldown_en == 1'b0, "R7", pulldown_en, 0);
                @(negedge clk);
            end
            chk(gate_kill == 1'b0, "R7", gate_kill, 0);
            check_gates("R7");
            repeat (LVL_MAX) @(negedge clk);
        end

        // R10: reset while the pull-down is on
        trip_in = 1'b1;
        repeat (2) @(negedge clk);
        chk(pulldown_en == 1'b1, "R10", pulldown_en, 1);
        rst_n = 1'b0;
        trip_in = 1'b0;
        @(negedge clk);
        chk(pulldown_en == 1'b0, "R10", pulldown_en, 0);
        chk(gate_kill == 1'b1, "R10", gate_kill, 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        wait_high("R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule